// File: doc/BRIEF.md
# Luma Bank Packer

The block sits behind a video front end that delivers 8-bit luma samples with a one-cycle valid strobe, together with pixel and line counters. It cuts the horizontal rate in half by keeping only alternate samples. It groups eight kept samples into one 64-bit word and writes each word into one of eight memory banks. The banks share one write data bus and one write address; a one-hot enable picks the bank that takes the word.

Lines rotate across the banks: every word of one image line lands in the same bank at consecutive addresses, and the next line goes to the next bank at the same base address. When bank 7 has received a full line, the base address moves up by one line of words (30) and the rotation starts again at bank 0. A consumer can therefore fetch eight vertically adjacent rows from the eight banks at a single address, which is the layout an 8x8 tile engine needs. A 240x240 field fills addresses 0 to 899 in every bank.

Top module: `luma_bank_packer`

## Requirements
- R1: Within a line, the phase flag flips on every accepted valid strobe. The 1st, 3rd, 5th… accepted samples are kept, and the others have no effect on any written word.
- R2: A line restart happens on any cycle with pixel counter 0 and line counter in 12..251 inclusive. A restart clears the decimation phase, the pixel position within the word and the word count of the line. A sample on the restart cycle counts as the first sample of the line. Samples whose line counter is outside 12..251 are ignored.
- R3: Packing order: the first kept pixel of a group is in bits 63:56 of the word and the eighth is in bits 7:0.
- R4: When the eighth kept pixel of a group is accepted, the next cycle shows that word on `wr_data`, its address on `wr_addr`, and exactly one bit of `wr_bank_en` high for one cycle only.
- R5: The address of word w (0..29) of a line is base + w. At most 30 words are written per line, and further kept samples of that line produce no write.
- R6: All words of a line use one bank. The bank index advances by one only after a line has written its 30th word; a shorter line leaves the bank unchanged.
- R7: When bank 7 completes a line, the next line uses bank 0 and a base 30 higher. After the base-870 group (last address 899), the base returns to 0.
- R8: A restart with line counter 12 (start of field) returns the bank index and the base to 0.
- R9: After reset, `wr_bank_en`, `wr_data` and `wr_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid | input | 1 | Luma sample strobe |
| luma | input | 8 (PIX_W) | Luma sample |
| pix_cnt | input | 10 (CNT_W) | Pixel position in the line from the front end |
| line_cnt | input | 10 (CNT_W) | Line number in the field from the front end |
| wr_data | output | 64 (PIX_W*LANES) | Packed word, shared by all banks |
| wr_addr | output | 10 | Word address, shared by all banks |
| wr_bank_en | output | 8 (BANKS) | One-hot bank write enable |

## Verification
On every cycle, the embedded properties check the following:
- the decimation never keeps two accepted samples in a row without a restart;
- a restart empties the word in progress;
- the line word count never passes 30, and addresses stay below 900;
- the bank and base change only at a completed line or at field start;
- the write enable is a single one-hot pulse.

Only the bench scenarios can show the values themselves:
- which samples end up in which byte of each word;
- that a short line is overwritten by the next one in the same bank;
- that an overlong line is truncated;
- that the base wraps after a full 240-line field;
- that a mid-line restart discards the partial word.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  // true when v lies in the closed interval [lo, hi]
  function automatic bit in_span(input int unsigned v, input int unsigned lo,
                                 input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // base of the next group of bank lines, folding back to zero at the end
  function automatic int unsigned step_base(input int unsigned base,
                                            input int unsigned stride,
                                            input int unsigned depth);
    return (base + stride >= depth) ? 0 : base + stride;
  endfunction

endpackage

// File: rtl/lbp_gate.sv
module lbp_gate
  import lbp_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned ACT_FIRST = 12,
  parameter int unsigned ACT_LAST  = 251
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [CNT_W-1:0] pix_cnt,
  input  logic [CNT_W-1:0] line_cnt,
  input  logic             line_full,
  output logic             restart,
  output logic             field_start,
  output logic             keep
);

  logic in_rng;
  logic armed_q;
  logic phase_q;
  logic phase_cur;
  logic accept;

  assign in_rng      = in_span(32'(line_cnt), ACT_FIRST, ACT_LAST);
  assign restart     = in_rng && (pix_cnt == '0);
  assign field_start = restart && (line_cnt == CNT_W'(ACT_FIRST));
  assign phase_cur   = restart ? 1'b0 : phase_q;
  assign accept      = pix_valid && in_rng && (armed_q || restart) &&
                       (restart || !line_full);
  assign keep        = accept && !phase_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      armed_q <= restart ? 1'b1 : (armed_q && in_rng);
      phase_q <= accept ? !phase_cur : phase_cur;
    end
  end

  // R1
  keep_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> (!keep || restart));

endmodule

// File: rtl/lbp_packer.sv
module lbp_packer #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 8,
  localparam int unsigned WORD_W = PIX_W * LANES,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              keep,
  input  logic [PIX_W-1:0]  pix,
  output logic              word_fire,
  output logic [WORD_W-1:0] word
);

  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] lane_cur;
  logic [PIX_W-1:0]  held_q [LANES-1];

  assign lane_cur  = restart ? '0 : lane_q;
  assign word_fire = keep && (lane_cur == LANE_W'(LANES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          lane_q <= '0;
    else if (word_fire)  lane_q <= '0;
    else if (keep)       lane_q <= lane_cur + 1'b1;
    else                 lane_q <= lane_cur;
  end

  // slot 0 is the newest pixel, slot LANES-1 the oldest
  for (genvar j = 0; j < LANES; j++) begin : g_slot
    if (j == 0) begin : g_new
      assign word[PIX_W-1:0] = pix;
      always_ff @(posedge clk) begin
        if (!rst_n)    held_q[0] <= '0;
        else if (keep) held_q[0] <= pix;
      end
    end else begin : g_old
      assign word[(j+1)*PIX_W-1 -: PIX_W] = held_q[j-1];
      if (j < LANES - 1) begin : g_shift
        always_ff @(posedge clk) begin
          if (!rst_n)    held_q[j] <= '0;
          else if (keep) held_q[j] <= held_q[j-1];
        end
      end
    end
  end

  // R2
  lane_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !keep) |=> (lane_q == '0));

endmodule

// File: rtl/lbp_sequencer.sv
module lbp_sequencer
  import lbp_pkg::*;
#(
  parameter int unsigned BANKS          = 8,
  parameter int unsigned WORDS_PER_LINE = 30,
  parameter int unsigned BANK_DEPTH     = 900,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned ADDR_W = $clog2(BANK_DEPTH),
  localparam int unsigned WCNT_W = $clog2(WORDS_PER_LINE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              field_start,
  input  logic              word_fire,
  output logic              line_full,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] word_addr
);

  logic [WCNT_W-1:0] wcnt_q;
  logic [WCNT_W-1:0] wcnt_cur;
  logic [ADDR_W-1:0] base_q;
  logic [BANK_W-1:0] bank_q;
  logic              line_done;

  assign wcnt_cur  = restart ? '0 : wcnt_q;
  assign line_full = (wcnt_q == WCNT_W'(WORDS_PER_LINE));
  assign line_done = word_fire && (wcnt_cur == WCNT_W'(WORDS_PER_LINE - 1));
  assign word_addr = base_q + ADDR_W'(wcnt_cur);
  assign bank      = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         wcnt_q <= '0;
    else if (word_fire) wcnt_q <= wcnt_cur + 1'b1;
    else                wcnt_q <= wcnt_cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || field_start) begin
      bank_q <= '0;
      base_q <= '0;
    end else if (line_done) begin
      if (bank_q == BANK_W'(BANKS - 1)) begin
        bank_q <= '0;
        base_q <= ADDR_W'(step_base(32'(base_q), WORDS_PER_LINE, BANK_DEPTH));
      end else begin
        bank_q <= bank_q + 1'b1;
      end
    end
  end

  // R5
  word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= WCNT_W'(WORDS_PER_LINE));
  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_fire |-> (word_addr < ADDR_W'(BANK_DEPTH)));
  // R6
  bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(line_done || field_start));
  // R7
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_q) |->
      $past(field_start || (line_done && bank_q == BANK_W'(BANKS - 1))));
  // R7
  base_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q <= ADDR_W'(BANK_DEPTH - WORDS_PER_LINE));
  // R8
  field_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (bank_q == '0 && base_q == '0));

endmodule

// File: rtl/luma_bank_packer.sv
module luma_bank_packer #(
  parameter int unsigned PIX_W          = 8,
  parameter int unsigned CNT_W          = 10,
  parameter int unsigned LANES          = 8,
  parameter int unsigned BANKS          = 8,
  parameter int unsigned WORDS_PER_LINE = 30,
  parameter int unsigned BANK_DEPTH     = 900,
  parameter int unsigned ACT_FIRST      = 12,
  parameter int unsigned ACT_LAST       = 251
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pix_valid,
  input  logic [PIX_W-1:0]              luma,
  input  logic [CNT_W-1:0]              pix_cnt,
  input  logic [CNT_W-1:0]              line_cnt,
  output logic [PIX_W*LANES-1:0]        wr_data,
  output logic [$clog2(BANK_DEPTH)-1:0] wr_addr,
  output logic [BANKS-1:0]              wr_bank_en
);

  localparam int unsigned WORD_W = PIX_W * LANES;
  localparam int unsigned ADDR_W = $clog2(BANK_DEPTH);
  localparam int unsigned BANK_W = $clog2(BANKS);

  logic              restart;
  logic              field_start;
  logic              keep;
  logic              line_full;
  logic              word_fire;
  logic [WORD_W-1:0] word;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] word_addr;

  lbp_gate #(
    .CNT_W(CNT_W), .ACT_FIRST(ACT_FIRST), .ACT_LAST(ACT_LAST)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_cnt(pix_cnt),
    .line_cnt(line_cnt), .line_full(line_full), .restart(restart),
    .field_start(field_start), .keep(keep)
  );

  lbp_packer #(
    .PIX_W(PIX_W), .LANES(LANES)
  ) u_packer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .keep(keep), .pix(luma),
    .word_fire(word_fire), .word(word)
  );

  lbp_sequencer #(
    .BANKS(BANKS), .WORDS_PER_LINE(WORDS_PER_LINE), .BANK_DEPTH(BANK_DEPTH)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .field_start(field_start),
    .word_fire(word_fire), .line_full(line_full), .bank(bank),
    .word_addr(word_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_data    <= '0;
      wr_addr    <= '0;
      wr_bank_en <= '0;
    end else begin
      wr_bank_en <= word_fire ? (BANKS'(1) << bank) : '0;
      if (word_fire) begin
        wr_data <= word;
        wr_addr <= word_addr;
      end
    end
  end

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bank_en != '0) |=> (wr_bank_en == '0));
  // R4
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_bank_en));

endmodule

// File: tb/luma_bank_packer_tb_top.sv
`timescale 1ns/1ps
module luma_bank_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  luma = '0;
  logic [9:0]  pix_cnt = 10'd1;
  logic [9:0]  line_cnt = '0;
  logic [63:0] wr_data;
  logic [9:0]  wr_addr;
  logic [7:0]  wr_bank_en;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  luma_bank_packer dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .luma(luma),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .wr_data(wr_data),
    .wr_addr(wr_addr), .wr_bank_en(wr_bank_en)
  );

  // write capture ring, only this block writes it
  int          wr_total = 0;
  logic [7:0]  cap_en   [64];
  logic [9:0]  cap_addr [64];
  logic [63:0] cap_data [64];

  always @(negedge clk) begin
    if (rst_n && wr_bank_en != '0) begin
      cap_en[wr_total % 64]   = wr_bank_en;
      cap_addr[wr_total % 64] = wr_addr;
      cap_data[wr_total % 64] = wr_data;
      wr_total++;
    end
  end

  // line, samples, gap, words, bank, base
  typedef struct packed {
    logic [9:0] line; logic [9:0] nsamp; logic [1:0] gap;
    logic [5:0] words; logic [2:0] bank; logic [9:0] base;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{10'd12,  10'd480, 2'd0, 6'd30, 3'd0, 10'd0},   // field start
    '{10'd13,  10'd480, 2'd1, 6'd30, 3'd1, 10'd0},   // spaced strobes
    '{10'd14,  10'd100, 2'd0, 6'd6,  3'd2, 10'd0},   // short line
    '{10'd15,  10'd500, 2'd0, 6'd30, 3'd2, 10'd0},   // overlong, same bank
    '{10'd16,  10'd15,  2'd0, 6'd1,  3'd3, 10'd0},   // exactly one word
    '{10'd17,  10'd480, 2'd0, 6'd30, 3'd3, 10'd0},
    '{10'd18,  10'd480, 2'd0, 6'd30, 3'd4, 10'd0},
    '{10'd19,  10'd480, 2'd0, 6'd30, 3'd5, 10'd0},
    '{10'd20,  10'd480, 2'd0, 6'd30, 3'd6, 10'd0},
    '{10'd21,  10'd480, 2'd0, 6'd30, 3'd7, 10'd0},
    '{10'd22,  10'd480, 2'd0, 6'd30, 3'd0, 10'd30},  // next group
    '{10'd5,   10'd480, 2'd0, 6'd0,  3'd0, 10'd0},   // below window
    '{10'd252, 10'd480, 2'd0, 6'd0,  3'd0, 10'd0},   // above window
    '{10'd12,  10'd480, 2'd0, 6'd30, 3'd0, 10'd0}    // field restart
  };

  function automatic logic [7:0] pix_f(int line, int k, int salt);
    return 8'(line * 7 + k * 3 + salt);
  endfunction

  // kept samples are the even-indexed ones; earliest lands highest
  function automatic logic [63:0] exp_word(int line, int salt, int w);
    logic [63:0] acc = '0;
    for (int j = 0; j < 8; j++) acc = {acc[55:0], pix_f(line, 2 * (8 * w + j), salt)};
    return acc;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic drive_line(int line, int nsamp, int gap, int salt, output int start);
    start = wr_total;
    @(posedge clk); #1;
    line_cnt = 10'(line); pix_cnt = '0; pix_valid = 1'b0;
    for (int k = 0; k < nsamp; k++) begin
      @(posedge clk); #1;
      pix_cnt = 10'(k + 1); pix_valid = 1'b1; luma = pix_f(line, k, salt);
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1; pix_valid = 1'b0;
      end
    end
    @(posedge clk); #1; pix_valid = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic verify_line(int line, int salt, int start, int words, int bank, int base);
    int n = wr_total - start;
    int bad = 0;
    check(n == words, "R5", $sformatf("line %0d word count", line), n, words);
    if (words > 0 && n > 0) begin
      check(cap_en[start % 64] == 8'(1 << bank), "R6",
            $sformatf("line %0d bank enable", line), cap_en[start % 64], 8'(1 << bank));
      check(cap_addr[start % 64] == 10'(base), "R5",
            $sformatf("line %0d first address", line), cap_addr[start % 64], base);
      for (int w = 0; w < n && w < words; w++) begin
        if (cap_data[(start + w) % 64] != exp_word(line, salt, w) ||
            cap_addr[(start + w) % 64] != 10'(base + w) ||
            cap_en[(start + w) % 64] != 8'(1 << bank)) begin
          if (bad == 0)
            check(1'b0, "R3", $sformatf("line %0d word %0d data", line, w),
                  cap_data[(start + w) % 64], exp_word(line, salt, w));
          bad++;
        end
      end
      if (bad == 0) check(1'b1, "R3", "packed words", 0, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int st;
    repeat (4) @(posedge clk);
    #1;
    // R9 reset state
    check(wr_bank_en == '0, "R9", "enable after reset", wr_bank_en, 0);
    check(wr_data == '0, "R9", "data after reset", wr_data, 0);
    check(wr_addr == '0, "R9", "address after reset", wr_addr, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // vector table: R1 R2 R5 R6 R7 R8
    for (int i = 0; i < 14; i++) begin
      vec_t v = VEC[i];
      drive_line(int'(v.line), int'(v.nsamp), int'(v.gap), 1, st);
      verify_line(int'(v.line), 1, st, int'(v.words), int'(v.bank), int'(v.base));
    end

    // full field then wrap of the base (R7)
    for (int i = 0; i < 240; i++) begin
      drive_line(12 + i, 480, 0, 9, st);
      verify_line(12 + i, 9, st, 30, i % 8, 30 * (i / 8));
      if (i == 239)
        check(cap_addr[(st + 29) % 64] == 10'd899, "R7", "last address of field",
              cap_addr[(st + 29) % 64], 899);
    end
    drive_line(100, 480, 0, 4, st);
    verify_line(100, 4, st, 30, 0, 0);   // R7 base folded to zero

    // mid-line restart drops the partial word and the phase (R2, R1)
    drive_line(30, 3, 0, 8'h55, st);
    check(wr_total - st == 0, "R2", "partial group writes nothing", wr_total - st, 0);
    drive_line(30, 16, 0, 8'h33, st);
    verify_line(30, 8'h33, st, 1, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule